// File: doc/BRIEF.md
# Interrupt Entry Sequencer for an 8-bit 6502-Style Core

This block produces the bus cycles an 8-bit 6502-family processor runs when it takes a hardware interrupt. The core pulses `begin_i` at each instruction boundary. If a request is pending at that edge, the block copies the current program counter, stack pointer and status register. It then drives the address bus, write data, read-not-write and the opcode-fetch strobe for seven cycles. When it finishes, it presents the handler address, the lowered stack pointer and the updated status for the core to load.

The entry is not folded into the tail of the previous instruction. It opens with a visible, aborted opcode fetch: the strobe is high, the address is PC and then PC+1, and the fetched bytes are discarded. Three stack writes follow, then a two-byte vector read. The non-maskable line is edge-sensitive and is latched on a falling edge. The maskable line is level-sensitive and is gated by the interrupt-disable flag. The non-maskable request wins when both are pending.

Top module: `irq_entry_seq`

## Requirements
- R1: An accepted entry keeps `busy_o` high for exactly 7 cycles, numbered 0 to 6. `done_o` is high only in cycle 6. `busy_o` is low in the cycle that follows.
- R2: Cycles 0 and 1 are reads from PC and from PC+1 (mod 65536). `sync_o` is high in cycle 0 and low in every other cycle, including idle cycles.
- R3: Cycles 2, 3 and 4 are writes (`rnw_o` low) to 0x0100+SP, 0x0100+SP-1 and 0x0100+SP-2, with the low byte wrapping inside page 1. The data written is PC[15:8], then PC[7:0], then the status with bit 4 (break) cleared and bit 5 (unused) set. `rnw_o` is high in every other cycle.
- R4: Cycles 5 and 6 read the low vector byte and then the high vector byte. The addresses are 0xFFFA/0xFFFB for the non-maskable request and 0xFFFE/0xFFFF for the maskable one. After the entry, `pc_o` = {byte read in cycle 6, byte read in cycle 5}.
- R5: After the entry, `sp_o` = SP-3 (mod 256). `sr_o` is the captured status with bit 2 (interrupt disable) set, bit 3 (decimal) cleared and all other bits unchanged.
- R6: A high-to-low transition on `nmi_n` latches a pending request, and accepting that request clears it. Keeping `nmi_n` low afterwards does not start another entry.
- R7: `irq_n` low starts an entry only while bit 2 of `sr_i` is clear. With bit 2 set, `begin_i` leaves `busy_o` low.
- R8: When a latched non-maskable request and an enabled maskable request are both present, the non-maskable request is taken first, using vector 0xFFFA. The maskable request can be taken at a later boundary.
- R9: Requests are accepted only on an edge where `begin_i` is high and the block is idle. A pending request with `begin_i` low does nothing, and `begin_i` during an entry is ignored.
- R10: While `rst_n` is low and after it is released: `busy_o`=0, `done_o`=0, `sync_o`=0, `rnw_o`=1, `addr_o`=0, `pc_o`=`sp_o`=`sr_o`=0, and no non-maskable request is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| begin_i | input | 1 | Instruction boundary, when requests are sampled |
| pc_i | input | 16 | Current program counter |
| sr_i | input | 8 | Current status register |
| sp_i | input | 8 | Current stack pointer |
| nmi_n | input | 1 | Non-maskable request, active low, edge-sensitive |
| irq_n | input | 1 | Maskable request, active low, level-sensitive |
| din_i | input | 8 | Read data bus |
| addr_o | output | 16 | Address bus |
| dout_o | output | 8 | Write data bus |
| rnw_o | output | 1 | High for read, low for write |
| sync_o | output | 1 | Opcode-fetch strobe |
| busy_o | output | 1 | Entry in progress |
| done_o | output | 1 | Last cycle of the entry |
| pc_o | output | 16 | Handler address after the entry |
| sp_o | output | 8 | Stack pointer after the entry |
| sr_o | output | 8 | Status register after the entry |

## Verification
The bench builds the block with its default parameters: stack in page 0x01, vectors at 0xFFFA and 0xFFFE, and the disable, decimal, break and unused flags at bits 2 to 5. With these values, small stack pointers make the push addresses wrap inside page 1, and a PC of 0xFFFF makes the dummy fetch address wrap to zero. Random program counters, stack pointers, status bytes and vector bytes are mixed with directed cases. The directed cases cover priority between simultaneous requests, the masked level request, an edge request held low across a boundary, and boundary pulses sent during an entry.

// File: rtl/irq_seq_pkg.sv
// Shared constants and types for the interrupt entry sequencer.
// Assumes the 8-bit data / 16-bit address organisation of the 6502 family.
package irq_seq_pkg;
    localparam int AW = 16;
    localparam int BW = 8;

    // One value per bus cycle of the entry; the order is the bus order.
    typedef enum logic [2:0] {
        ST_FETCH0   = 3'd0,
        ST_FETCH1   = 3'd1,
        ST_PUSH_PCH = 3'd2,
        ST_PUSH_PCL = 3'd3,
        ST_PUSH_SR  = 3'd4,
        ST_VEC_LO   = 3'd5,
        ST_VEC_HI   = 3'd6
    } step_e;

    // Core state captured when an entry is accepted.
    typedef struct packed {
        logic [AW-1:0] pc;
        logic [BW-1:0] sp;
        logic [BW-1:0] sr;
        logic          is_nmi;
    } snap_t;
endpackage

// File: rtl/irq_req_capture.sv
// Request capture and priority.
// Latches a falling edge on nmi_n as a pending request and clears it when
// that request is taken. irq_n is level-sensitive and is gated by the
// interrupt-disable flag. A pending NMI outranks IRQ.
// Assumes nmi_n and irq_n are already synchronous to clk.
module irq_req_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    input  logic irq_n,
    input  logic i_flag_i,
    input  logic take_i,
    output logic req_o,
    output logic sel_nmi_o
);
    logic nmi_q;
    logic pend_q;
    logic fall;
    logic irq_ok;

    assign fall = nmi_q && !nmi_n;

    // Track the previous nmi_n level and the pending flag (a new edge wins over a clear).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q  <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            nmi_q <= nmi_n;
            if (fall)
                pend_q <= 1'b1;
            else if (take_i && sel_nmi_o)
                pend_q <= 1'b0;
        end
    end

    // Decide which request is presented to the sequencer.
    always_comb begin
        irq_ok    = !irq_n && !i_flag_i;
        sel_nmi_o = pend_q;
        req_o     = pend_q || irq_ok;
    end

    // R6
    // pending edge request drops only when it is taken
    nmi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_q) |-> $past(take_i && sel_nmi_o));
endmodule

// File: rtl/irq_step_ctr.sv
// Cycle counter for the entry.
// A start pulse moves the block from idle to step 0. It then advances one step
// per clock and returns to idle after the last step.
// Assumes start_i is raised only while the block is idle.
module irq_step_ctr
    import irq_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start_i,
    output logic  busy_o,
    output step_e step_o
);
    logic  busy_q;
    step_e step_q;

    // Advance the step while busy; leave busy after the last step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            step_q <= ST_FETCH0;
        end else if (start_i && !busy_q) begin
            busy_q <= 1'b1;
            step_q <= ST_FETCH0;
        end else if (busy_q) begin
            if (step_q == ST_VEC_HI) begin
                busy_q <= 1'b0;
                step_q <= ST_FETCH0;
            end else begin
                step_q <= step_e'(step_q + 3'd1);
            end
        end
    end

    assign busy_o = busy_q;
    assign step_o = step_q;

    // R1
    // steps advance by one per cycle without skipping
    step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && step_q != ST_VEC_HI) |=>
        (busy_q && (3'(step_q) == 3'($past(step_q)) + 3'd1)));
endmodule

// File: rtl/irq_bus_mux.sv
// Bus driver for the entry.
// Maps the current step and the captured state onto the address, write data,
// read-not-write and sync outputs. Purely combinational.
// Assumes snap_i is stable for the whole entry.
module irq_bus_mux
    import irq_seq_pkg::*;
#(
    parameter logic [BW-1:0] STACK_PAGE = 8'h01,
    parameter logic [AW-1:0] NMI_VEC    = 16'hFFFA,
    parameter logic [AW-1:0] IRQ_VEC    = 16'hFFFE,
    parameter int            B_BIT      = 4,
    parameter int            U_BIT      = 5
) (
    input  logic          busy_i,
    input  step_e         step_i,
    input  snap_t         snap_i,
    output logic [AW-1:0] addr_o,
    output logic [BW-1:0] dout_o,
    output logic          rnw_o,
    output logic          sync_o
);
    logic [AW-1:0] vec_base;
    logic [BW-1:0] push_sr;

    // Select the vector and form the status byte that goes on the stack.
    always_comb begin
        vec_base = snap_i.is_nmi ? NMI_VEC : IRQ_VEC;
        push_sr  = snap_i.sr;
        push_sr[B_BIT] = 1'b0;
        push_sr[U_BIT] = 1'b1;
    end

    // Drive the bus for the active step; idle leaves a quiet read at address 0.
    always_comb begin
        addr_o = '0;
        dout_o = '0;
        rnw_o  = 1'b1;
        sync_o = 1'b0;
        if (busy_i) begin
            unique case (step_i)
                ST_FETCH0: begin
                    addr_o = snap_i.pc;
                    sync_o = 1'b1;
                end
                ST_FETCH1:   addr_o = snap_i.pc + 16'd1;
                ST_PUSH_PCH: begin
                    addr_o = {STACK_PAGE, snap_i.sp};
                    dout_o = snap_i.pc[AW-1:BW];
                    rnw_o  = 1'b0;
                end
                ST_PUSH_PCL: begin
                    addr_o = {STACK_PAGE, snap_i.sp - 8'd1};
                    dout_o = snap_i.pc[BW-1:0];
                    rnw_o  = 1'b0;
                end
                ST_PUSH_SR: begin
                    addr_o = {STACK_PAGE, snap_i.sp - 8'd2};
                    dout_o = push_sr;
                    rnw_o  = 1'b0;
                end
                ST_VEC_LO:   addr_o = vec_base;
                ST_VEC_HI:   addr_o = vec_base + 16'd1;
                default:     addr_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_entry_seq.sv
// Top of the interrupt entry sequencer.
// When begin_i is high at an instruction boundary and a request is present,
// it captures PC/SP/status and runs the 7-cycle entry: aborted fetch, three
// pushes, vector read. It then holds the handler PC, the new SP and the new status.
// Assumes the core keeps pc_i/sp_i/sr_i valid on the begin_i edge.
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter logic [BW-1:0] STACK_PAGE = 8'h01,
    parameter logic [AW-1:0] NMI_VEC    = 16'hFFFA,
    parameter logic [AW-1:0] IRQ_VEC    = 16'hFFFE,
    parameter int            I_BIT      = 2,
    parameter int            D_BIT      = 3,
    parameter int            B_BIT      = 4,
    parameter int            U_BIT      = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          begin_i,
    input  logic [AW-1:0] pc_i,
    input  logic [BW-1:0] sr_i,
    input  logic [BW-1:0] sp_i,
    input  logic          nmi_n,
    input  logic          irq_n,
    input  logic [BW-1:0] din_i,
    output logic [AW-1:0] addr_o,
    output logic [BW-1:0] dout_o,
    output logic          rnw_o,
    output logic          sync_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [AW-1:0] pc_o,
    output logic [BW-1:0] sp_o,
    output logic [BW-1:0] sr_o
);
    localparam logic [BW-1:0] PUSH_COUNT = 8'd3;

    logic          req;
    logic          sel_nmi;
    logic          accept;
    logic          busy;
    step_e         step;
    snap_t         snap_q;
    logic [BW-1:0] vlo_q;
    logic [AW-1:0] pc_q;
    logic [BW-1:0] sp_q;
    logic [BW-1:0] sr_q;

    assign accept = begin_i && !busy && req;

    irq_req_capture u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .nmi_n     (nmi_n),
        .irq_n     (irq_n),
        .i_flag_i  (sr_i[I_BIT]),
        .take_i    (accept),
        .req_o     (req),
        .sel_nmi_o (sel_nmi)
    );

    irq_step_ctr u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (accept),
        .busy_o  (busy),
        .step_o  (step)
    );

    irq_bus_mux #(
        .STACK_PAGE (STACK_PAGE),
        .NMI_VEC    (NMI_VEC),
        .IRQ_VEC    (IRQ_VEC),
        .B_BIT      (B_BIT),
        .U_BIT      (U_BIT)
    ) u_bus (
        .busy_i (busy),
        .step_i (step),
        .snap_i (snap_q),
        .addr_o (addr_o),
        .dout_o (dout_o),
        .rnw_o  (rnw_o),
        .sync_o (sync_o)
    );

    assign done_o = busy && (step == ST_VEC_HI);

    // Capture the core state on acceptance; record the vector low byte in step 5.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
            vlo_q  <= '0;
        end else begin
            if (accept) begin
                snap_q.pc     <= pc_i;
                snap_q.sp     <= sp_i;
                snap_q.sr     <= sr_i;
                snap_q.is_nmi <= sel_nmi;
            end
            if (busy && step == ST_VEC_LO)
                vlo_q <= din_i;
        end
    end

    // Load the post-entry PC, SP and status as the last cycle ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
            sp_q <= '0;
            sr_q <= '0;
        end else if (done_o) begin
            pc_q        <= {din_i, vlo_q};
            sp_q        <= snap_q.sp - PUSH_COUNT;
            sr_q        <= snap_q.sr;
            sr_q[I_BIT] <= 1'b1;
            sr_q[D_BIT] <= 1'b0;
        end
    end

    assign busy_o = busy;
    assign pc_o   = pc_q;
    assign sp_o   = sp_q;
    assign sr_o   = sr_q;

    // R9
    // an entry starts only from a boundary pulse
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(begin_i));

    // R1
    // the last cycle is followed by idle
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o);

    // R3
    // writes happen only inside an entry
    write_in_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rnw_o |-> busy_o);

    // R2
    // the fetch strobe lasts a single cycle and is a read
    sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |-> (rnw_o ##1 !sync_o));
endmodule

// File: tb/irq_entry_seq_tb_top.sv
`timescale 1ns/1ps
module irq_entry_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        begin_i = 1'b0;
    logic [15:0] pc_i = '0;
    logic [7:0]  sr_i = '0;
    logic [7:0]  sp_i = '0;
    logic        nmi_n = 1'b1;
    logic        irq_n = 1'b1;
    logic [7:0]  din_i;
    logic [15:0] addr_o;
    logic [7:0]  dout_o;
    logic        rnw_o, sync_o, busy_o, done_o;
    logic [15:0] pc_o;
    logic [7:0]  sp_o, sr_o;

    int tests = 0;
    int fails = 0;
    logic [15:0] vec_nmi = 16'h1234;
    logic [15:0] vec_irq = 16'h5678;

    always #4 clk = ~clk;

    irq_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .begin_i(begin_i), .pc_i(pc_i), .sr_i(sr_i),
        .sp_i(sp_i), .nmi_n(nmi_n), .irq_n(irq_n), .din_i(din_i),
        .addr_o(addr_o), .dout_o(dout_o), .rnw_o(rnw_o), .sync_o(sync_o),
        .busy_o(busy_o), .done_o(done_o), .pc_o(pc_o), .sp_o(sp_o), .sr_o(sr_o)
    );

    function automatic logic [7:0] mem_rd(input logic [15:0] a);
        case (a)
            16'hFFFA: mem_rd = vec_nmi[7:0];
            16'hFFFB: mem_rd = vec_nmi[15:8];
            16'hFFFE: mem_rd = vec_irq[7:0];
            16'hFFFF: mem_rd = vec_irq[15:8];
            default:  mem_rd = a[7:0] ^ 8'h5A;
        endcase
    endfunction

    always_comb din_i = mem_rd(addr_o);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] push_sr(input logic [7:0] s);
        push_sr = (s & ~8'h10) | 8'h20;
    endfunction

    // Drive one boundary with a request present and check every cycle of the entry.
    task automatic run_entry(input bit nmi, input logic [15:0] pc, input logic [7:0] sp,
                             input logic [7:0] sr, input bit poke);
        logic [15:0] vb = nmi ? 16'hFFFA : 16'hFFFE;
        logic [15:0] vec = nmi ? vec_nmi : vec_irq;
        pc_i = pc; sp_i = sp; sr_i = sr; begin_i = 1'b1;
        @(negedge clk);
        begin_i = 1'b0;
        for (int k = 0; k < 7; k++) begin
            logic [15:0] ea; logic erw; logic [7:0] ed; logic [31:0] act, exp;
            erw = !(k >= 2 && k <= 4);
            case (k)
                0: begin ea = pc;               ed = 8'h00; end
                1: begin ea = pc + 16'd1;       ed = 8'h00; end
                2: begin ea = {8'h01, sp};       ed = pc[15:8]; end
                3: begin ea = {8'h01, sp - 8'd1}; ed = pc[7:0]; end
                4: begin ea = {8'h01, sp - 8'd2}; ed = push_sr(sr); end
                5: begin ea = vb;               ed = 8'h00; end
                default: begin ea = vb + 16'd1; ed = 8'h00; end
            endcase
            act = {addr_o, rnw_o ? 8'h00 : dout_o, 1'b0, busy_o, done_o, sync_o, 3'b0, rnw_o};
            exp = {ea, ed, 1'b0, 1'b1, (k == 6), (k == 0), 3'b0, erw};
            chk(act == exp, (k < 2) ? "R2" : (k < 5) ? "R3" : "R4 R1", act, exp);
            if (poke && k == 2) begin_i = 1'b1;   // R9: boundary pulse mid-entry
            if (k == 3) begin_i = 1'b0;
            @(negedge clk);
        end
        chk(busy_o == 1'b0, "R1", busy_o, 0);
        chk(pc_o == vec, "R4", pc_o, vec);
        chk(sp_o == sp - 8'd3, "R5", sp_o, sp - 8'd3);
        chk(sr_o == ((sr | 8'h04) & ~8'h08), "R5", sr_o, (sr | 8'h04) & ~8'h08);
    endtask

    task automatic no_entry(input string req);
        begin_i = 1'b1;
        @(negedge clk);
        begin_i = 1'b0;
        chk(busy_o == 1'b0 && rnw_o == 1'b1 && sync_o == 1'b0, req, {busy_o, rnw_o, sync_o}, 3'b010);
    endtask

    task automatic nmi_fall();
        nmi_n = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int unsigned seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        // R10 reset state
        chk({busy_o, done_o, sync_o, rnw_o, addr_o} == {4'b0001, 16'h0}, "R10",
            {busy_o, done_o, sync_o, rnw_o, addr_o}, {4'b0001, 16'h0});
        chk({pc_o, sp_o, sr_o} == 32'h0, "R10", {pc_o, sp_o, sr_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        no_entry("R10");   // no pending edge request after reset

        // R9: requests present but no boundary pulse
        irq_n = 1'b0; sr_i = 8'h00;
        repeat (4) @(negedge clk);
        chk(busy_o == 1'b0, "R9", busy_o, 0);
        // R7 level request taken, with boundary pulses mid-entry ignored (R9)
        run_entry(1'b0, 16'h8000, 8'hFD, 8'h08, 1'b1);
        // R7 masked level request
        sr_i = 8'h04;
        no_entry("R7");
        irq_n = 1'b1;

        // R6 edge request, then held low without retrigger
        nmi_fall();
        run_entry(1'b1, 16'hFFFF, 8'h01, 8'hFF, 1'b0);   // wraps PC+1 and stack page
        no_entry("R6");
        nmi_n = 1'b1;
        @(negedge clk);

        // R8 both pending: NMI first, IRQ at a later boundary
        vec_nmi = 16'hA5C3; vec_irq = 16'h3C5A;
        irq_n = 1'b0;
        nmi_fall();
        run_entry(1'b1, 16'h0200, 8'h00, 8'h00, 1'b0);
        nmi_n = 1'b1;
        run_entry(1'b0, 16'h0300, 8'h80, 8'h00, 1'b0);
        irq_n = 1'b1;
        sr_i = 8'h00;
        no_entry("R9");

        // Random entries
        for (int i = 0; i < 40; i++) begin
            bit nm = $urandom_range(0, 1);
            logic [15:0] pc = 16'($urandom);
            logic [7:0] sp = 8'($urandom);
            logic [7:0] sr = 8'($urandom);
            vec_nmi = 16'($urandom);
            vec_irq = 16'($urandom);
            if (nm) begin
                nmi_fall();
                run_entry(1'b1, pc, sp, sr, 1'($urandom_range(0, 1)));
                nmi_n = 1'b1;
            end else begin
                sr[2] = 1'b0;
                irq_n = 1'b0;
                run_entry(1'b0, pc, sp, sr, 1'($urandom_range(0, 1)));
                irq_n = 1'b1;
            end
            @(negedge clk);
        end
        if (seed == 32'hFFFF_FFFF) $display("seed edge");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule